// File: doc/BRIEF.md
# DMA Bus-Master Cycle Sequencer

This block carries out single external bus transfers for a DMA engine that shares a multiplexed 16-bit address/data bus with a host processor. When the DMA core raises a start request, the sequencer asks for the bus with an active-low request. It waits for the active-low grant, then presents a 32-bit address in two halves on the AD lines: the upper half under an upper address strobe, then the lower half under a lower address strobe. It finishes with one read or write data phase under a data strobe. While it owns the bus it drives a read/write level and a 2-bit code naming the channel it serves.

A slow target can stretch the data phase through one handshake pin. A configuration write picks the pin's meaning. In the extend mode a low level holds the cycle open. In the acknowledge mode the cycle closes only once the pin goes low. The pin passes through a two-stage synchronizer before use. If the grant is withdrawn during an address or data phase, the sequencer lets go of the bus in the same cycle and reports an abort. A completed transfer is reported with a done pulse.

States: `ST_IDLE` (bus released), `ST_REQ` (request out, waiting for grant), `ST_ADDR_HI`, `ST_ADDR_LO`, `ST_DATA` (stays while the handshake stalls), `ST_DONE` (one cycle, done pulse). Transitions: IDLE→REQ on start; REQ→ADDR_HI on grant; ADDR_HI→ADDR_LO and ADDR_LO→DATA when the grant is held; DATA→DONE when the handshake allows completion; DONE→IDLE always. ADDR_HI, ADDR_LO or DATA go →IDLE when the grant is lost (abort).

Top module: `dma_bus_sequencer`

## Requirements
- R1: A start request in IDLE brings `busreq_n` low from the next cycle until the DONE cycle or an abort. No strobe is low and `ad_oe` is 0 while the grant (`busack_n` low) has not arrived.
- R2: The first cycle after the grant is seen drives `uas_n` low for exactly one cycle, with `ad_oe`=1 and `ad_out` = address bits 31..16. This always comes before `as_n` goes low.
- R3: The cycle after the upper phase drives `as_n` low for exactly one cycle, with `ad_out` = address bits 15..0 and `uas_n` high. At most one of the three strobes is low in any cycle.
- R4: In the data phase `ds_n` is low and `rw` is 1 for a read and 0 for a write. `ad_oe` is 1 with `ad_out` = write data only for a write. For a read, `rdata` holds the `ad_in` value of the last data cycle from the DONE cycle on.
- R5: A cycle with `cfg_wr`=1 sets the handshake mode: `cfg_a1`=1 selects extend mode and `cfg_a1`=0 selects acknowledge mode. Reset selects extend mode, and `cfg_a1` has no effect while `cfg_wr`=0.
- R6: In extend mode the data phase stays open while the synchronized handshake is low and completes when it is high.
- R7: In acknowledge mode the data phase completes only when the synchronized handshake is low.
- R8: The handshake passes through two flip-flops. If the pin is at its completing level before the data phase, the phase lasts one cycle. If it changes to that level K cycles after the first data cycle, the phase lasts K+3 cycles.
- R9: `chan_code` equals the channel given with the start request while the grant is held in the address and data phases, and is 00 in every other cycle.
- R10: If `busack_n` goes high during an address or data phase, the strobes go high and `ad_oe` and `chan_code` return to 0 in that same cycle. In the next cycle `abort_pulse` is 1 for one cycle, `busreq_n` is high and no done pulse follows.
- R11: `done_pulse` is 1 for exactly one cycle, the cycle after the last data cycle, with `busreq_n` high. `done_pulse` and `abort_pulse` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start one transfer (taken in IDLE) |
| start_write | input | 1 | 1 = write transfer, 0 = read |
| start_addr | input | 32 | Transfer address |
| start_wdata | input | 16 | Write data |
| start_chan | input | 2 | Channel number of the transfer |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_a1 | input | 1 | Mode select bit sampled with cfg_wr |
| busack_n | input | 1 | Bus grant, active low |
| hs_n | input | 1 | Wait/acknowledge handshake pin, active low |
| ad_in | input | 16 | AD bus input |
| busreq_n | output | 1 | Bus request, active low |
| uas_n | output | 1 | Upper address strobe, active low |
| as_n | output | 1 | Lower address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw | output | 1 | 1 = read, 0 = write |
| ad_out | output | 16 | AD bus output value |
| ad_oe | output | 1 | AD bus output enable |
| chan_code | output | 2 | Active channel code |
| rdata | output | 16 | Captured read data |
| done_pulse | output | 1 | Transfer complete, one cycle |
| abort_pulse | output | 1 | Transfer aborted, one cycle |

## Verification
All strobes, `ad_oe`, `ad_out`, `rw` and `chan_code` come from the state register gated by the raw grant. So `busreq_n` is due one cycle after start, the upper phase one cycle after the grant is driven, and the grant-loss release is due in the very cycle the grant drops. The data phase lasts one cycle, or K+3 cycles when the handshake is released K cycles into it, because of the two synchronizer flops. Done is due the cycle after the last data cycle, and abort the cycle after the grant drops. The bench drives and samples only on the falling clock edge, and counts data-phase cycles rather than waiting for an event, so each result is compared in the exact cycle it is due.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_REQ     = 3'd1,
        ST_ADDR_HI = 3'd2,
        ST_ADDR_LO = 3'd3,
        ST_DATA    = 3'd4,
        ST_DONE    = 3'd5
    } dbs_state_t;

endpackage

// File: rtl/dbs_hs_sync.sv
module dbs_hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic sync_n
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[i] <= 1'b1;
                end else if (i == 0) begin
                    chain[i] <= pin_n;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign sync_n = chain[STAGES-1];

endmodule

// File: rtl/dbs_mode_reg.sv
module dbs_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_a1,
    output logic mode_extend
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_extend <= 1'b1;
        end else if (cfg_wr) begin
            mode_extend <= cfg_a1;
        end
    end

endmodule

// File: rtl/dbs_fsm.sv
module dbs_fsm
    import dbs_pkg::*;
#(
    parameter int AD_W = 16,
    parameter int CH_W = 2,
    localparam int ADDR_W = 2 * AD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_write,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [AD_W-1:0]   start_wdata,
    input  logic [CH_W-1:0]   start_chan,
    input  logic              busack_n,
    input  logic              hs_sync_n,
    input  logic              mode_extend,
    input  logic [AD_W-1:0]   ad_in,
    output logic              busreq_n,
    output logic              uas_n,
    output logic              as_n,
    output logic              ds_n,
    output logic              rw,
    output logic [AD_W-1:0]   ad_out,
    output logic              ad_oe,
    output logic [CH_W-1:0]   chan_code,
    output logic [AD_W-1:0]   rdata,
    output logic              done_pulse,
    output logic              abort_pulse
);

    dbs_state_t state, state_nx;

    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [AD_W-1:0]   wdata_q;
    logic [CH_W-1:0]   chan_q;
    logic              abort_q;

    logic grant;
    logic active;
    logic lost;
    logic data_go;
    logic finish;

    assign grant   = !busack_n;
    assign active  = (state == ST_ADDR_HI) || (state == ST_ADDR_LO) || (state == ST_DATA);
    assign lost    = active && !grant;
    assign data_go = mode_extend ? hs_sync_n : !hs_sync_n;
    assign finish  = (state == ST_DATA) && grant && data_go;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_REQ;
            ST_REQ:     if (grant) state_nx = ST_ADDR_HI;
            ST_ADDR_HI: state_nx = grant ? ST_ADDR_LO : ST_IDLE;
            ST_ADDR_LO: state_nx = grant ? ST_DATA : ST_IDLE;
            ST_DATA: begin
                if (!grant)       state_nx = ST_IDLE;
                else if (data_go) state_nx = ST_DONE;
            end
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            chan_q  <= '0;
            abort_q <= 1'b0;
            rdata   <= '0;
        end else begin
            state   <= state_nx;
            abort_q <= lost;
            if (state == ST_IDLE && start) begin
                wr_q    <= start_write;
                addr_q  <= start_addr;
                wdata_q <= start_wdata;
                chan_q  <= start_chan;
            end
            if (finish && !wr_q) begin
                rdata <= ad_in;
            end
        end
    end

    always_comb begin
        busreq_n    = 1'b1;
        uas_n       = 1'b1;
        as_n        = 1'b1;
        ds_n        = 1'b1;
        rw          = 1'b1;
        ad_out      = '0;
        ad_oe       = 1'b0;
        chan_code   = '0;
        done_pulse  = (state == ST_DONE);
        abort_pulse = abort_q;
        if (state == ST_REQ || (active && grant)) begin
            busreq_n = 1'b0;
        end
        if (active && grant) begin
            rw        = !wr_q;
            chan_code = chan_q;
            unique case (state)
                ST_ADDR_HI: begin
                    uas_n  = 1'b0;
                    ad_oe  = 1'b1;
                    ad_out = addr_q[ADDR_W-1:AD_W];
                end
                ST_ADDR_LO: begin
                    as_n   = 1'b0;
                    ad_oe  = 1'b1;
                    ad_out = addr_q[AD_W-1:0];
                end
                ST_DATA: begin
                    ds_n   = 1'b0;
                    ad_oe  = wr_q;
                    ad_out = wr_q ? wdata_q : '0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dma_bus_sequencer.sv
module dma_bus_sequencer #(
    parameter int AD_W        = 16,
    parameter int CH_W        = 2,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = 2 * AD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_write,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [AD_W-1:0]   start_wdata,
    input  logic [CH_W-1:0]   start_chan,
    input  logic              cfg_wr,
    input  logic              cfg_a1,
    input  logic              busack_n,
    input  logic              hs_n,
    input  logic [AD_W-1:0]   ad_in,
    output logic              busreq_n,
    output logic              uas_n,
    output logic              as_n,
    output logic              ds_n,
    output logic              rw,
    output logic [AD_W-1:0]   ad_out,
    output logic              ad_oe,
    output logic [CH_W-1:0]   chan_code,
    output logic [AD_W-1:0]   rdata,
    output logic              done_pulse,
    output logic              abort_pulse
);

    logic hs_sync_n;
    logic mode_extend;

    dbs_hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (hs_n),
        .sync_n (hs_sync_n)
    );

    dbs_mode_reg u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_a1      (cfg_a1),
        .mode_extend (mode_extend)
    );

    dbs_fsm #(.AD_W(AD_W), .CH_W(CH_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_write (start_write),
        .start_addr  (start_addr),
        .start_wdata (start_wdata),
        .start_chan  (start_chan),
        .busack_n    (busack_n),
        .hs_sync_n   (hs_sync_n),
        .mode_extend (mode_extend),
        .ad_in       (ad_in),
        .busreq_n    (busreq_n),
        .uas_n       (uas_n),
        .as_n        (as_n),
        .ds_n        (ds_n),
        .rw          (rw),
        .ad_out      (ad_out),
        .ad_oe       (ad_oe),
        .chan_code   (chan_code),
        .rdata       (rdata),
        .done_pulse  (done_pulse),
        .abort_pulse (abort_pulse)
    );

endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
    parameter int CH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busack_n,
    input logic            busreq_n,
    input logic            uas_n,
    input logic            as_n,
    input logic            ds_n,
    input logic            rw,
    input logic            ad_oe,
    input logic [CH_W-1:0] chan_code,
    input logic            done_pulse,
    input logic            abort_pulse
);

    p_strobe_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!uas_n || !as_n || !ds_n) |-> !busreq_n);

    p_oe_needs_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> !busack_n);

    p_upper_before_lower_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(as_n) |-> $past(!uas_n));

    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!uas_n, !as_n, !ds_n}) <= 1);

    p_write_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n && !rw) |-> ad_oe);

    p_chan_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busreq_n |-> (chan_code == '0));

    p_abort_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse);

    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    p_done_abort_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_pulse && abort_pulse));

endmodule

bind dma_bus_sequencer dbs_checker #(.CH_W(CH_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busack_n    (busack_n),
    .busreq_n    (busreq_n),
    .uas_n       (uas_n),
    .as_n        (as_n),
    .ds_n        (ds_n),
    .rw          (rw),
    .ad_oe       (ad_oe),
    .chan_code   (chan_code),
    .done_pulse  (done_pulse),
    .abort_pulse (abort_pulse)
);

// File: tb/sim_dma_bus_sequencer.sv
`timescale 1ns/1ps
module sim_dma_bus_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, start_write = 1'b0;
    logic [31:0] start_addr = '0;
    logic [15:0] start_wdata = '0;
    logic [1:0]  start_chan = '0;
    logic        cfg_wr = 1'b0, cfg_a1 = 1'b0;
    logic        busack_n = 1'b1, hs_n = 1'b1;
    logic [15:0] ad_in = '0;
    logic        busreq_n, uas_n, as_n, ds_n, rw, ad_oe, done_pulse, abort_pulse;
    logic [15:0] ad_out, rdata;
    logic [1:0]  chan_code;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dma_bus_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_write(start_write),
        .start_addr(start_addr), .start_wdata(start_wdata), .start_chan(start_chan),
        .cfg_wr(cfg_wr), .cfg_a1(cfg_a1), .busack_n(busack_n), .hs_n(hs_n),
        .ad_in(ad_in), .busreq_n(busreq_n), .uas_n(uas_n), .as_n(as_n),
        .ds_n(ds_n), .rw(rw), .ad_out(ad_out), .ad_oe(ad_oe),
        .chan_code(chan_code), .rdata(rdata), .done_pulse(done_pulse),
        .abort_pulse(abort_pulse)
    );

    typedef struct packed {
        logic        wr;
        logic        a1;
        logic        stall;
        logic [3:0]  k;
        logic [3:0]  g;
        logic [1:0]  ch;
        logic [31:0] addr;
        logic [15:0] dat;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 1'b0, 4'd0, 4'd0, 2'd1, 32'hA5C3_1E0F, 16'h5AA5},
        '{1'b1, 1'b1, 1'b1, 4'd2, 4'd1, 2'd2, 32'h0001_FFFE, 16'hC0DE},
        '{1'b0, 1'b0, 1'b0, 4'd0, 4'd3, 2'd3, 32'hFFFF_0000, 16'h1234},
        '{1'b1, 1'b0, 1'b1, 4'd4, 4'd0, 2'd0, 32'h8000_0001, 16'hBEEF},
        '{1'b0, 1'b0, 1'b1, 4'd0, 4'd2, 2'd2, 32'h1357_9BDF, 16'h0F0F},
        '{1'b1, 1'b1, 1'b1, 4'd1, 4'd0, 2'd1, 32'h2468_ACE0, 16'hFFFF}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                summary();
            end
        end
    end

    task automatic cfg_write(input logic a1);
        cfg_wr = 1'b1;
        cfg_a1 = a1;
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_a1 = ~a1;
    endtask

    // Starts a transfer and walks it up to the first data cycle.
    task automatic begin_xfer(input vec_t v);
        start       = 1'b1;
        start_write = v.wr;
        start_addr  = v.addr;
        start_wdata = v.dat;
        start_chan  = v.ch;
        ad_in       = v.dat;
        @(negedge clk);
        start = 1'b0;
        chk(busreq_n == 1'b0, "R1 request low", busreq_n, 0);
        chk(ad_oe == 1'b0 && uas_n && as_n && ds_n, "R1 nothing driven before grant", ad_oe, 0);
        for (int i = 0; i < v.g; i++) begin
            @(negedge clk);
            chk(busreq_n == 1'b0 && uas_n == 1'b1 && ad_oe == 1'b0, "R1 holding for grant", {busreq_n, uas_n, ad_oe}, 3'b010);
        end
        busack_n = 1'b0;
        @(negedge clk);
        chk(uas_n == 1'b0 && as_n == 1'b1, "R2 upper strobe", {uas_n, as_n}, 2'b01);
        chk(ad_oe == 1'b1 && ad_out == v.addr[31:16], "R2 upper address", ad_out, v.addr[31:16]);
        chk(chan_code == v.ch, "R9 channel code", chan_code, v.ch);
        @(negedge clk);
        chk(as_n == 1'b0 && uas_n == 1'b1 && ds_n == 1'b1, "R3 lower strobe", {uas_n, as_n, ds_n}, 3'b101);
        chk(ad_oe == 1'b1 && ad_out == v.addr[15:0], "R3 lower address", ad_out, v.addr[15:0]);
        @(negedge clk);
    endtask

    task automatic run_xfer(input vec_t v, input bit extend);
        int n;
        int exp_n;
        logic go_lvl;
        go_lvl = extend ? 1'b1 : 1'b0;
        hs_n = v.stall ? ~go_lvl : go_lvl;
        repeat (2) @(negedge clk);
        begin_xfer(v);
        n = 0;
        while (ds_n == 1'b0 && n < 40) begin
            chk(rw == ~v.wr, "R4 rw level", rw, ~v.wr);
            chk(ad_oe == v.wr && (!v.wr || ad_out == v.dat), "R4 data drive", {ad_oe, ad_out}, {v.wr, v.wr ? v.dat : 16'h0});
            chk(done_pulse == 1'b0, "R11 no early done", done_pulse, 0);
            if (v.stall && n == v.k) hs_n = go_lvl;
            n++;
            @(negedge clk);
        end
        exp_n = v.stall ? v.k + 3 : 1;
        chk(n == exp_n, extend ? "R6 R8 extend mode data length" : "R7 R8 acknowledge mode data length", n, exp_n);
        chk(done_pulse == 1'b1 && abort_pulse == 1'b0, "R11 done pulse", {done_pulse, abort_pulse}, 2'b10);
        chk(busreq_n == 1'b1 && ad_oe == 1'b0 && chan_code == 2'd0, "R11 R9 bus released at done", {busreq_n, ad_oe, chan_code}, 4'b1000);
        if (!v.wr) chk(rdata == v.dat, "R4 read data", rdata, v.dat);
        @(negedge clk);
        chk(done_pulse == 1'b0, "R11 done one cycle", done_pulse, 0);
        busack_n = 1'b1;
    endtask

    initial begin
        vec_t d;
        repeat (3) @(negedge clk);
        chk(busreq_n && uas_n && as_n && ds_n, "R1 reset strobes high", {busreq_n, uas_n, as_n, ds_n}, 4'hF);
        chk(!ad_oe && !done_pulse && !abort_pulse && chan_code == 0, "R11 reset outputs", {ad_oe, done_pulse, abort_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: reset mode is extend; pin held high completes in one cycle
        d = '{1'b0, 1'b1, 1'b0, 4'd0, 4'd0, 2'd3, 32'h1111_2222, 16'h3333};
        run_xfer(d, 1'b1);

        for (int i = 0; i < NVEC; i++) begin
            cfg_write(VECS[i].a1);
            run_xfer(VECS[i], VECS[i].a1);
        end

        // R5: cfg_a1 without cfg_wr does not switch back to extend mode (mode is acknowledge now? set it)
        cfg_write(1'b0);
        cfg_a1 = 1'b1;
        repeat (2) @(negedge clk);
        d = '{1'b1, 1'b0, 1'b1, 4'd2, 4'd0, 2'd2, 32'hCAFE_0042, 16'h7E7E};
        run_xfer(d, 1'b0);
        cfg_a1 = 1'b0;

        // R10: grant lost in lower address phase
        cfg_write(1'b1);
        hs_n = 1'b1;
        d = '{1'b0, 1'b1, 1'b0, 4'd0, 4'd0, 2'd1, 32'hDEAD_BEEF, 16'h4444};
        start = 1'b1; start_write = d.wr; start_addr = d.addr; start_chan = d.ch;
        @(negedge clk);
        start = 1'b0;
        busack_n = 1'b0;
        @(negedge clk);
        chk(uas_n == 1'b0, "R2 upper strobe before abort", uas_n, 0);
        @(negedge clk);
        busack_n = 1'b1;
        #1;
        chk(as_n == 1'b1 && ad_oe == 1'b0 && chan_code == 0, "R10 release same cycle", {as_n, ad_oe, chan_code}, 4'b1000);
        @(negedge clk);
        chk(abort_pulse == 1'b1 && done_pulse == 1'b0, "R10 abort pulse", {abort_pulse, done_pulse}, 2'b10);
        chk(busreq_n == 1'b1 && ds_n == 1'b1, "R10 bus released after abort", {busreq_n, ds_n}, 2'b11);
        @(negedge clk);
        chk(abort_pulse == 1'b0 && done_pulse == 1'b0, "R10 abort one cycle", {abort_pulse, done_pulse}, 0);

        // R10: grant lost while the data phase is stalled in extend mode
        hs_n = 1'b0;
        repeat (2) @(negedge clk);
        d = '{1'b1, 1'b1, 1'b1, 4'd9, 4'd0, 2'd2, 32'h0F0F_F0F0, 16'hA1A1};
        begin_xfer(d);
        chk(ds_n == 1'b0 && ad_oe == 1'b1, "R6 stalled data phase", {ds_n, ad_oe}, 2'b01);
        @(negedge clk);
        chk(ds_n == 1'b0, "R6 still stalled", ds_n, 0);
        busack_n = 1'b1;
        #1;
        chk(ds_n == 1'b1 && ad_oe == 1'b0, "R10 data release same cycle", {ds_n, ad_oe}, 2'b10);
        @(negedge clk);
        chk(abort_pulse == 1'b1 && done_pulse == 1'b0, "R10 abort in data", {abort_pulse, done_pulse}, 2'b10);
        hs_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(done_pulse == 1'b0 && busreq_n == 1'b1, "R10 no done after abort", {done_pulse, busreq_n}, 2'b01);
        end

        summary();
    end

endmodule